// File: doc/BRIEF.md
# Conditional Skip Sequencer

This block is the fetch and execute control for a processor core that has a one-word prefetch and 16-bit instruction words. An instruction cycle lasts four clock phases. While one word executes, the next word is already being fetched. The sequencer decides whether that prefetched word runs in the following cycle or is replaced by a no-operation.

It tests the conditions of the compare, test-for-zero, increment/decrement and bit-test skip instructions. It uses the operand byte, the working register and the bit index held in the word. Jumps, calls and returns always cost two cycles, so after one of them the following word is squashed as well.

The core presents the executing word, the operand byte and the working register during the cycle, and the sequencer samples them in the last phase. It drives a phase count, a program-counter increment strobe, a squash flag that covers the whole next cycle, and a count of completed instruction cycles.

Top module: `skip_seq`

## Requirements
- R1: `phase` counts 0, 1, 2, 3 and wraps, advancing once per clock. It is 0 during and right after reset.
- R2: `pc_inc` is high exactly while `phase` is 0.
- R3: `cycles` increases by one, wrapping, at the clock edge that ends phase 3, and holds its value at all other edges.
- R4: The word and operands are sampled only at the edge that ends phase 3. `squash` changes only at that edge and then stays constant for a full instruction cycle.
- R5: Top byte 0x30 skips when operand < wreg. 0x31 skips when operand = wreg. 0x32 skips when operand > wreg. Both ordering tests are unsigned.
- R6: Top byte 0x33 skips when the operand is zero.
- R7: Top byte 0x16/0x17 skips when operand−1 is zero. 0x1E/0x1F skips when operand+1 is zero (modulo 256). 0x26/0x27 skips when operand−1 is non-zero. 0x24/0x25 skips when operand+1 is non-zero.
- R8: Top byte 1001_0bbb skips when operand bit bbb is set. 1001_1bbb skips when that bit is clear. bbb is word bits [10:8].
- R9: These words always squash the next word: top bits [15:14] = 11 (jump/call), top byte 0xB6 (return with literal), and the whole words 0x0002 and 0x0005 (returns).
- R10: A squashed cycle never squashes the cycle after it, whatever word is presented in it. A squash therefore covers exactly one word.
- R11: Any other word leaves `squash` low. Examples are 0x0000, 0x0E00, 0x1400, 0x3400, 0xB0FF and 0x0003.
- R12: Reset is synchronous and active low. While it is held, `squash` is 0, `cycles` is 0 and `phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Word in the execute stage |
| opnd | input | 8 | Operand byte read for that word |
| wreg | input | 8 | Working register value |
| phase | output | 2 | Phase within the instruction cycle |
| pc_inc | output | 1 | Program-counter increment strobe |
| squash | output | 1 | Current cycle executes as a no-operation |
| cycles | output | CNT_W | Completed instruction cycles |

## Verification
A wrong skip decision shows on `squash` one clock after the deciding phase-3 edge, and it persists for four clocks, so a single check per cycle catches it. A corrupted phase counter moves the `pc_inc` strobe and the cycle boundary at once, and this is visible within one instruction cycle. A squash flag that fails to clear, or that chains, shows up in the cycle after a squashed word as a second squashed cycle.

// File: rtl/skip_seq_pkg.sv
// Shared widths and the skip classification used by the sequencer.
package skip_seq_pkg;
    localparam int INSTR_W = 16;
    localparam int DATA_W  = 8;
    localparam int BIT_W   = $clog2(DATA_W);

    typedef enum logic [3:0] {
        K_NONE, K_CMP_LT, K_CMP_EQ, K_CMP_GT, K_TST_Z,
        K_DEC_Z, K_INC_Z, K_DEC_NZ, K_INC_NZ,
        K_BIT_SET, K_BIT_CLR, K_FLOW
    } skip_kind_e;
endpackage

// File: rtl/skip_phase_gen.sv
// Phase counter and instruction-cycle counter.
// Assumes PHASES >= 2; the last phase marks the instruction-cycle boundary.
module skip_phase_gen #(
    parameter int PHASES = 4,
    parameter int CNT_W  = 16,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PH_W-1:0]  phase,
    output logic             last,
    output logic [CNT_W-1:0] cycles
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    logic [PH_W-1:0]  ph_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance the phase and wrap it at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= '0;
        else if (ph_q == LAST_PH)
            ph_q <= '0;
        else
            ph_q <= ph_q + 1'b1;
    end

    // Count each completed instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ph_q == LAST_PH)
            cnt_q <= cnt_q + 1'b1;
    end

    assign phase  = ph_q;
    assign last   = (ph_q == LAST_PH);
    assign cycles = cnt_q;
endmodule

// File: rtl/skip_decode.sv
// Classifies an instruction word by its skip or flow-change behaviour and
// extracts the bit index. Purely combinational.
module skip_decode
    import skip_seq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output skip_kind_e         kind,
    output logic [BIT_W-1:0]   bit_idx
);
    logic [7:0] op;
    assign op      = instr[INSTR_W-1 -: 8];
    assign bit_idx = instr[8 +: BIT_W];

    // Map the opcode byte (and whole word for returns) to a skip kind.
    always_comb begin
        kind = K_NONE;
        casez (op)
            8'h30:        kind = K_CMP_LT;
            8'h31:        kind = K_CMP_EQ;
            8'h32:        kind = K_CMP_GT;
            8'h33:        kind = K_TST_Z;
            8'b0001_011?: kind = K_DEC_Z;
            8'b0001_111?: kind = K_INC_Z;
            8'b0010_011?: kind = K_DEC_NZ;
            8'b0010_010?: kind = K_INC_NZ;
            8'b1001_0???: kind = K_BIT_SET;
            8'b1001_1???: kind = K_BIT_CLR;
            8'b11??_????: kind = K_FLOW;
            8'hB6:        kind = K_FLOW;
            8'h00: begin
                if (instr[7:0] == 8'h02 || instr[7:0] == 8'h05)
                    kind = K_FLOW;
            end
            default:      kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/skip_cond.sv
// Evaluates whether the classified instruction takes its skip (or flow change).
// Comparisons are unsigned; inc/dec results wrap modulo 2**DATA_W.
module skip_cond
    import skip_seq_pkg::*;
(
    input  skip_kind_e        kind,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] wreg,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              take
);
    logic [DATA_W-1:0] dec_res;
    logic [DATA_W-1:0] inc_res;
    logic              sel_bit;

    assign dec_res = opnd - 1'b1;
    assign inc_res = opnd + 1'b1;
    assign sel_bit = opnd[bit_idx];

    // Select the condition that belongs to the instruction kind.
    always_comb begin
        case (kind)
            K_CMP_LT:  take = (opnd < wreg);
            K_CMP_EQ:  take = (opnd == wreg);
            K_CMP_GT:  take = (opnd > wreg);
            K_TST_Z:   take = (opnd == '0);
            K_DEC_Z:   take = (dec_res == '0);
            K_INC_Z:   take = (inc_res == '0);
            K_DEC_NZ:  take = (dec_res != '0);
            K_INC_NZ:  take = (inc_res != '0);
            K_BIT_SET: take = sel_bit;
            K_BIT_CLR: take = !sel_bit;
            K_FLOW:    take = 1'b1;
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/skip_seq.sv
// Top of the conditional skip sequencer. Samples the executing word at the
// last phase and registers a squash flag for the next instruction cycle.
// Assumes the core holds instr/opnd/wreg valid in the last phase.
module skip_seq
    import skip_seq_pkg::*;
#(
    parameter int PHASES = 4,
    parameter int CNT_W  = 16,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  opnd,
    input  logic [DATA_W-1:0]  wreg,
    output logic [PH_W-1:0]    phase,
    output logic               pc_inc,
    output logic               squash,
    output logic [CNT_W-1:0]   cycles
);
    skip_kind_e       kind;
    logic [BIT_W-1:0] bit_idx;
    logic             take;
    logic             cyc_end;
    logic             squash_q;

    skip_phase_gen #(.PHASES(PHASES), .CNT_W(CNT_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .last   (cyc_end),
        .cycles (cycles)
    );

    skip_decode u_dec (
        .instr   (instr),
        .kind    (kind),
        .bit_idx (bit_idx)
    );

    skip_cond u_cond (
        .kind    (kind),
        .opnd    (opnd),
        .wreg    (wreg),
        .bit_idx (bit_idx),
        .take    (take)
    );

    // A squashed word is a no-op, so it never squashes its successor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            squash_q <= 1'b0;
        else if (cyc_end)
            squash_q <= !squash_q && take;
    end

    assign squash = squash_q;
    assign pc_inc = (phase == '0);
endmodule

// File: rtl/skip_seq_chk.sv
// Assertion checker for skip_seq, attached with bind below.
module skip_seq_chk #(
    parameter int PHASES = 4,
    parameter int CNT_W  = 16,
    localparam int PH_W  = $clog2(PHASES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      instr,
    input logic [PH_W-1:0]  phase,
    input logic             pc_inc,
    input logic             squash,
    input logic [CNT_W-1:0] cycles
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST_PH) |=> (phase == PH_W'($past(phase) + 1'b1)));

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_PH) |=> (phase == '0));

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |=> !pc_inc);

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_PH) |=> (cycles == CNT_W'($past(cycles) + 1'b1)));

    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST_PH) |=> $stable(cycles));

    p_squash_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST_PH) |=> $stable(squash));

    p_flow_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_PH && !squash && instr[15:14] == 2'b11) |=> squash);

    p_no_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_PH && squash) |=> !squash);
endmodule

bind skip_seq skip_seq_chk #(.PHASES(PHASES), .CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .instr  (instr),
    .phase  (phase),
    .pc_inc (pc_inc),
    .squash (squash),
    .cycles (cycles)
);

// File: tb/skip_seq_tb_top.sv
// Bench: vector table of skip decisions, then directed reset and corner tests.
module skip_seq_tb_top;
    localparam int CNT_W = 16;
    localparam int NVEC  = 33;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      instr = '0;
    logic [7:0]       opnd = '0;
    logic [7:0]       wreg = '0;
    logic [1:0]       phase;
    logic             pc_inc;
    logic             squash;
    logic [CNT_W-1:0] cycles;

    int n_vec = 0;
    int n_bad = 0;
    int ncyc  = 0;

    always #2.5 clk = ~clk;

    skip_seq #(.PHASES(4), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .opnd(opnd), .wreg(wreg),
        .phase(phase), .pc_inc(pc_inc), .squash(squash), .cycles(cycles)
    );

    // {requirement, word, operand, wreg, expected squash}
    localparam logic [36:0] VEC [NVEC] = '{
        {4'd5,  16'h3000, 8'h05, 8'h10, 1'b1},  // R5 less-than
        {4'd5,  16'h3000, 8'h10, 8'h05, 1'b0},
        {4'd5,  16'h3000, 8'hFF, 8'h01, 1'b0},  // R5 unsigned
        {4'd5,  16'h3000, 8'h01, 8'hFF, 1'b1},
        {4'd5,  16'h3100, 8'h7A, 8'h7A, 1'b1},  // R5 equal
        {4'd5,  16'h3100, 8'h7A, 8'h7B, 1'b0},
        {4'd5,  16'h3200, 8'h80, 8'h7F, 1'b1},  // R5 greater, unsigned
        {4'd5,  16'h3200, 8'h7F, 8'h7F, 1'b0},
        {4'd6,  16'h3300, 8'h00, 8'h55, 1'b1},  // R6
        {4'd6,  16'h3300, 8'h01, 8'h00, 1'b0},
        {4'd7,  16'h1600, 8'h01, 8'h00, 1'b1},  // R7 dec, zero
        {4'd7,  16'h1742, 8'h02, 8'h00, 1'b0},
        {4'd7,  16'h1E00, 8'hFF, 8'h00, 1'b1},  // R7 inc, zero
        {4'd7,  16'h1F00, 8'hFE, 8'h00, 1'b0},
        {4'd7,  16'h2600, 8'h01, 8'h00, 1'b0},  // R7 dec, non-zero
        {4'd7,  16'h2700, 8'h00, 8'h00, 1'b1},
        {4'd7,  16'h2400, 8'hFF, 8'h00, 1'b0},  // R7 inc, non-zero
        {4'd7,  16'h2500, 8'h00, 8'h00, 1'b1},
        {4'd8,  16'h9300, 8'h08, 8'h00, 1'b1},  // R8 bit set test
        {4'd8,  16'h9300, 8'hF7, 8'h00, 1'b0},
        {4'd8,  16'h9F00, 8'h7F, 8'h00, 1'b1},  // R8 bit clear test
        {4'd8,  16'h9F00, 8'h80, 8'h00, 1'b0},
        {4'd8,  16'h9800, 8'hFE, 8'h00, 1'b1},
        {4'd9,  16'hC123, 8'h00, 8'h00, 1'b1},  // R9 jump
        {4'd9,  16'hE000, 8'h00, 8'h00, 1'b1},  // R9 call
        {4'd9,  16'h0002, 8'h00, 8'h00, 1'b1},  // R9 return
        {4'd9,  16'h0005, 8'h00, 8'h00, 1'b1},
        {4'd9,  16'hB6AA, 8'h00, 8'h00, 1'b1},
        {4'd11, 16'h0000, 8'h00, 8'h00, 1'b0},  // R11 other words
        {4'd11, 16'h0E00, 8'h00, 8'h00, 1'b0},
        {4'd11, 16'h1400, 8'hFF, 8'h00, 1'b0},
        {4'd11, 16'h3400, 8'h00, 8'h00, 1'b0},
        {4'd11, 16'hB0FF, 8'h00, 8'h00, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One instruction cycle, starting at the negedge in phase 0.
    task automatic run_cycle(input logic [15:0] w, input logic [7:0] f, input logic [7:0] r);
        instr = w; opnd = f; wreg = r;
        repeat (4) @(posedge clk);
        @(negedge clk);
        ncyc++;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state, R1 and R2 at reset
        check("R12", {31'd0, squash}, 32'd0);
        check("R12", cycles, 32'd0);
        check("R1", phase, 32'd0);
        check("R2", pc_inc, 32'd1);
        rst_n = 1'b1;

        // R1/R2: phase walk over two instruction cycles
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check("R1", phase, k % 4);
            check("R2", pc_inc, (k % 4) == 0);
        end
        ncyc = 2;

        // Vector table; R10 checked on the cycle after each squash
        for (int i = 0; i < NVEC; i++) begin
            run_cycle(VEC[i][32:17], VEC[i][16:9], VEC[i][8:1]);
            check($sformatf("R%0d vec %0d", VEC[i][36:33], i), squash, VEC[i][0]);
            if (squash) begin
                run_cycle(16'h0000, 8'h00, 8'h00);
                check("R10", squash, 32'd0);
            end
        end

        // R4: squash is constant at every phase of the squashed cycle
        run_cycle(16'hC000, 8'h00, 8'h00);
        instr = 16'h0000;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check("R4", squash, 32'd1);
        end
        @(negedge clk);
        ncyc++;
        check("R10", squash, 32'd0);

        // R4: word present only before the last phase is not sampled
        instr = 16'hC000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        instr = 16'h0000;
        @(posedge clk);
        @(negedge clk);
        ncyc++;
        check("R4", squash, 32'd0);

        // R10: a flow change or true skip inside a squashed cycle does not chain
        run_cycle(16'h3100, 8'h11, 8'h11);
        check("R5", squash, 32'd1);
        run_cycle(16'hC000, 8'h00, 8'h00);
        check("R10", squash, 32'd0);
        run_cycle(16'hE000, 8'h00, 8'h00);
        check("R9", squash, 32'd1);
        run_cycle(16'h3300, 8'h00, 8'h00);
        check("R10", squash, 32'd0);

        // R3: cycle count matches the cycles run
        check("R3", cycles, ncyc);
        @(negedge clk);
        check("R3", cycles, ncyc);

        // R12: reset in mid-flight with squash pending
        instr = 16'hC000;
        repeat (3) @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R9", squash, 32'd1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R12", squash, 32'd0);
        check("R12", cycles, 32'd0);
        check("R12", phase, 32'd0);
        finish_run();
    end
endmodule